// File: doc/BRIEF.md
# SPI Port Control and Status Register

This block is the control word of a small SPI port, together with the byte queues and the shift logic behind it. A processor reaches it over a simple single-cycle read/write bus. The bus has two locations. The control location holds the mode selects, the command bits, the bit counts and the live queue status. The data location pushes a byte into the 8-entry transmit queue when written and pops the 8-entry receive queue when read.

The port-configuration inputs come from outside the block: master/slave role, three-wire mode, clock idle polarity and a slave-select delay code. In master mode a queued byte is shifted out MSB first. It carries 1 to 8 bits, with the field code 000 meaning a full byte. A read phase, requested through the control word, shifts in a programmable number of bits and stores them right-justified. Full duplex captures MISO while a byte is sent. Two commands clear themselves: one runs a burst of clock pulses with no data, the other empties both queues and clears the error flag. The slave-select line is either driven by hand from the control word or raised and lowered around each data transfer.

Top module: `spi_ctl_port`

## Requirements
- R1: After reset the control location reads 0x0280: transmit-ready (bit 9) and transmit-empty (bit 7) are 1 and every other bit is 0. ss_n is 1, sck equals cfg_cpol, mosi is 0 and fifo_err is 0.
- R2: Bit 13 (transfer style), bit 11, bits 5:3 (transmit count) and bits 2:0 (receive count) read back as last written. Writes to the status bits 9:6 change nothing. Bit 14 reads 0.
- R3: Bit 12 (full duplex) takes the written value, except that it stays 0 when it is written while cfg_three_wire is 1.
- R4: In master mode with cfg_ss_dly equal to 0, ss_n is the inverse of bit 11. With a nonzero cfg_ss_dly, bit 11 is ignored and ss_n is low for exactly the cycles of a data transfer. Clock-only bursts leave ss_n high.
- R5: Status bits: bit 9 means the transmit queue is not full, bit 8 means the receive queue is not empty, bit 7 means the transmit queue is empty and bit 6 means the receive queue is full. Each queue holds 8 bytes.
- R6: Writing the data location while the transmit queue is full, or reading it while the receive queue is empty, sets fifo_err. fifo_err stays 1 until a queue-reset command.
- R7: Writing 1 to bit 14 empties both queues and clears fifo_err on the next edge.
- R8: In master mode an idle port with a queued byte pops that byte and sends its top N bits MSB first. N is the transmit count, with 000 meaning 8. Each bit lasts 2*SCK_HALF clocks, and mosi is stable on the active sck edge.
- R9: Writing 1 to bit 10 in master mode starts a read of N receive-count bits from MISO, right-justified into the receive queue. A queued transmit byte goes first. Bit 10 reads 1 until the read starts, then 0.
- R10: With bit 12 set, a transmit transfer also captures as many MISO bits as it sends and pushes them, right-justified, into the receive queue.
- R11: Writing 1 to bit 15 is accepted only in master mode with the engine idle. It then produces STROBE_PULSES sck pulses with mosi at 0, and bit 15 reads 1 until the burst ends. Otherwise the write has no effect.
- R12: In slave mode (cfg_master 0) no transfer or burst starts, sck stays at cfg_cpol, ss_n stays 1, and bit 10 holds its written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write access |
| bus_rd | input | 1 | Read access |
| bus_addr | input | ADDR_W | 0 selects the control word, 1 selects the data location |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational during a read, 0 otherwise |
| cfg_master | input | 1 | 1 selects master role |
| cfg_three_wire | input | 1 | Three-wire mode, blocks full duplex |
| cfg_cpol | input | 1 | Idle level of sck |
| cfg_ss_dly | input | SS_DLY_W | 0 selects manual slave select |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | 1 | Active-low slave select |
| fifo_err | output | 1 | Queue overflow/underflow flag |

## Verification
The transmit side and the read phase both claim the engine in the same idle cycle when a byte is queued and bit 10 is written straight afterwards. The bench writes the data location and then the control word on consecutive bus slots, and reads the control word while the first byte is still shifting. It judges the outcome by bit 10 still reading 1 mid-transfer, by sixteen sck pulses whose first eight mosi bits equal the queued byte, and by the receive queue then holding the MISO bits of the second eight pulses. Status bits and the queue pointers are also exercised against the engine's pop and push in back-to-back reads.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

  // Control word bit positions
  localparam int B_STROBE = 15;
  localparam int B_INIT   = 14;
  localparam int B_STYLE  = 13;
  localparam int B_DUPLEX = 12;
  localparam int B_SSMAN  = 11;
  localparam int B_RDEN   = 10;
  localparam int B_TXRDY  = 9;
  localparam int B_RXAV   = 8;
  localparam int B_TXEMP  = 7;
  localparam int B_RXFULL = 6;

  typedef enum logic [1:0] {
    XF_NONE = 2'd0,
    XF_WR   = 2'd1,
    XF_RD   = 2'd2,
    XF_STB  = 2'd3
  } xfer_e;

  // 000 means a whole byte
  function automatic logic [3:0] len_decode(input logic [2:0] f);
    return (f == 3'd0) ? 4'd8 : {1'b0, f};
  endfunction

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CMAX);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
      if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp_q] <= din;
  end

  // R5
  fifo_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CMAX);

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> full);

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_ctl_pkg::*;
#(
  parameter int SCK_HALF      = 2,
  parameter int STROBE_PULSES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       master,
  input  logic       cpol,
  input  logic       full_dup,
  input  logic       tx_valid,
  input  logic [7:0] tx_byte,
  input  logic [2:0] tx_len,
  input  logic [2:0] rx_len,
  input  logic       rd_req,
  input  logic       strobe_go,
  input  logic       miso,
  output logic       tx_pop,
  output logic       rd_start,
  output logic       rx_push,
  output logic [7:0] rx_byte,
  output logic       busy,
  output logic       xfer_active,
  output logic       strobe_active,
  output logic       sck,
  output logic       mosi
);
  localparam int MAXB   = (STROBE_PULSES > 8) ? STROBE_PULSES : 8;
  localparam int BITS_W = $clog2(MAXB + 1);
  localparam int PH_W   = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [PH_W-1:0]   PH_MAX = PH_W'(SCK_HALF - 1);
  localparam logic [BITS_W-1:0] STB_N  = BITS_W'(STROBE_PULSES);

  logic              run_q, run_d;
  logic              half_q, half_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic [BITS_W-1:0] bits_q, bits_d;
  xfer_e             mode_q, mode_d;
  logic              cap_q, cap_d;
  logic [7:0]        sho_q, sho_d;
  logic [7:0]        shi_q, shi_d;

  always_comb begin
    run_d    = run_q;
    half_d   = half_q;
    ph_d     = ph_q;
    bits_d   = bits_q;
    mode_d   = mode_q;
    cap_d    = cap_q;
    sho_d    = sho_q;
    shi_d    = shi_q;
    tx_pop   = 1'b0;
    rd_start = 1'b0;
    rx_push  = 1'b0;
    if (!run_q) begin
      if (strobe_go) begin
        run_d  = 1'b1;
        mode_d = XF_STB;
        cap_d  = 1'b0;
        sho_d  = '0;
        bits_d = STB_N;
      end else if (master && tx_valid) begin
        run_d  = 1'b1;
        mode_d = XF_WR;
        cap_d  = full_dup;
        sho_d  = tx_byte;
        bits_d = BITS_W'(len_decode(tx_len));
        tx_pop = 1'b1;
      end else if (master && rd_req) begin
        run_d    = 1'b1;
        mode_d   = XF_RD;
        cap_d    = 1'b1;
        sho_d    = '0;
        bits_d   = BITS_W'(len_decode(rx_len));
        rd_start = 1'b1;
      end
      half_d = 1'b0;
      ph_d   = '0;
      shi_d  = '0;
    end else if (ph_q == PH_MAX) begin
      ph_d = '0;
      if (!half_q) begin
        half_d = 1'b1;
        shi_d  = {shi_q[6:0], miso};
      end else begin
        half_d = 1'b0;
        sho_d  = {sho_q[6:0], 1'b0};
        bits_d = bits_q - 1'b1;
        if (bits_q == BITS_W'(1)) begin
          run_d   = 1'b0;
          mode_d  = XF_NONE;
          rx_push = cap_q;
        end
      end
    end else begin
      ph_d = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      half_q <= 1'b0;
      ph_q   <= '0;
      bits_q <= '0;
      mode_q <= XF_NONE;
      cap_q  <= 1'b0;
      sho_q  <= '0;
      shi_q  <= '0;
    end else begin
      run_q  <= run_d;
      half_q <= half_d;
      ph_q   <= ph_d;
      bits_q <= bits_d;
      mode_q <= mode_d;
      cap_q  <= cap_d;
      sho_q  <= sho_d;
      shi_q  <= shi_d;
    end
  end

  assign busy          = run_q;
  assign strobe_active = run_q && (mode_q == XF_STB);
  assign xfer_active   = run_q && (mode_q != XF_STB);
  assign rx_byte       = shi_q;
  assign sck           = cpol ^ (run_q && half_q);
  assign mosi          = run_q && sho_q[7];

  // R8
  pop_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> (busy && mode_q == XF_WR));

  // R9
  one_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_pop && rd_start));

  // R11
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_active |-> !mosi && !rx_push);

endmodule

// File: rtl/spi_ctl_port.sv
module spi_ctl_port
  import spi_ctl_pkg::*;
#(
  parameter int ADDR_W        = 1,
  parameter int SS_DLY_W      = 2,
  parameter int FIFO_DEPTH    = 8,
  parameter int SCK_HALF      = 2,
  parameter int STROBE_PULSES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [15:0]         bus_wdata,
  output logic [15:0]         bus_rdata,
  input  logic                cfg_master,
  input  logic                cfg_three_wire,
  input  logic                cfg_cpol,
  input  logic [SS_DLY_W-1:0] cfg_ss_dly,
  input  logic                miso,
  output logic                sck,
  output logic                mosi,
  output logic                ss_n,
  output logic                fifo_err
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(1);

  logic ctl_wr, ctl_rd, dat_wr, dat_rd;
  logic style_q, style_d, dup_q, dup_d, ssman_q, ssman_d, rden_q, rden_d;
  logic [2:0] txlen_q, txlen_d, rxlen_q, rxlen_d;
  logic err_q, err_d;
  logic init_cmd, strobe_go;

  logic       tx_empty, tx_full, rx_empty, rx_full;
  logic [7:0] tx_dout, rx_dout, rx_byte;
  logic       tx_pop, rd_start, rx_push;
  logic       busy, xfer_active, strobe_active;

  assign ctl_wr = bus_sel && bus_wr && (bus_addr == CTRL_ADDR);
  assign ctl_rd = bus_sel && bus_rd && (bus_addr == CTRL_ADDR);
  assign dat_wr = bus_sel && bus_wr && (bus_addr == DATA_ADDR);
  assign dat_rd = bus_sel && bus_rd && (bus_addr == DATA_ADDR);

  assign init_cmd  = ctl_wr && bus_wdata[B_INIT];
  assign strobe_go = ctl_wr && bus_wdata[B_STROBE] && cfg_master && !busy;

  // Next state of the writable fields
  always_comb begin
    style_d = style_q;
    dup_d   = dup_q;
    ssman_d = ssman_q;
    rden_d  = rden_q;
    txlen_d = txlen_q;
    rxlen_d = rxlen_q;
    if (ctl_wr) begin
      style_d = bus_wdata[B_STYLE];
      dup_d   = bus_wdata[B_DUPLEX] && !cfg_three_wire;
      ssman_d = bus_wdata[B_SSMAN];
      rden_d  = bus_wdata[B_RDEN];
      txlen_d = bus_wdata[5:3];
      rxlen_d = bus_wdata[2:0];
    end else if (rd_start) begin
      rden_d = 1'b0;
    end
    if (init_cmd) err_d = 1'b0;
    else          err_d = err_q || (dat_wr && tx_full) || (dat_rd && rx_empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      style_q <= 1'b0;
      dup_q   <= 1'b0;
      ssman_q <= 1'b0;
      rden_q  <= 1'b0;
      txlen_q <= '0;
      rxlen_q <= '0;
      err_q   <= 1'b0;
    end else begin
      style_q <= style_d;
      dup_q   <= dup_d;
      ssman_q <= ssman_d;
      rden_q  <= rden_d;
      txlen_q <= txlen_d;
      rxlen_q <= rxlen_d;
      err_q   <= err_d;
    end
  end

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(init_cmd),
    .push(dat_wr), .din(bus_wdata[7:0]), .pop(tx_pop),
    .dout(tx_dout), .empty(tx_empty), .full(tx_full)
  );

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(init_cmd),
    .push(rx_push), .din(rx_byte), .pop(dat_rd),
    .dout(rx_dout), .empty(rx_empty), .full(rx_full)
  );

  spi_shift_engine #(.SCK_HALF(SCK_HALF), .STROBE_PULSES(STROBE_PULSES)) u_eng (
    .clk(clk), .rst_n(rst_n), .master(cfg_master), .cpol(cfg_cpol),
    .full_dup(dup_q), .tx_valid(!tx_empty), .tx_byte(tx_dout),
    .tx_len(txlen_q), .rx_len(rxlen_q), .rd_req(rden_q),
    .strobe_go(strobe_go), .miso(miso),
    .tx_pop(tx_pop), .rd_start(rd_start), .rx_push(rx_push), .rx_byte(rx_byte),
    .busy(busy), .xfer_active(xfer_active), .strobe_active(strobe_active),
    .sck(sck), .mosi(mosi)
  );

  always_comb begin
    bus_rdata = '0;
    if (ctl_rd) begin
      bus_rdata[B_STROBE] = strobe_active;
      bus_rdata[B_STYLE]  = style_q;
      bus_rdata[B_DUPLEX] = dup_q;
      bus_rdata[B_SSMAN]  = ssman_q;
      bus_rdata[B_RDEN]   = rden_q;
      bus_rdata[B_TXRDY]  = !tx_full;
      bus_rdata[B_RXAV]   = !rx_empty;
      bus_rdata[B_TXEMP]  = tx_empty;
      bus_rdata[B_RXFULL] = rx_full;
      bus_rdata[5:3]      = txlen_q;
      bus_rdata[2:0]      = rxlen_q;
    end else if (dat_rd && !rx_empty) begin
      bus_rdata[7:0] = rx_dout;
    end
  end

  always_comb begin
    if (!cfg_master)            ss_n = 1'b1;
    else if (cfg_ss_dly == '0)  ss_n = !ssman_q;
    else                        ss_n = !xfer_active;
  end

  assign fifo_err = err_q;

  // R3
  dup_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && cfg_three_wire) |=> !dup_q);

  // R7
  init_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_cmd |=> (tx_empty && rx_empty && !fifo_err));

  // R9
  rden_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $fell(rden_q) && !$past(ctl_wr)) |-> $past(rd_start));

  // R12
  slave_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_master && !busy) |=> !busy);

endmodule

// File: tb/sim_spi_ctl_port.sv
module sim_spi_ctl_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int WD_CYCLES = 200000;

  logic        clk, rst_n;
  logic        bus_sel, bus_wr, bus_rd;
  logic [0:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        cfg_master, cfg_three_wire, cfg_cpol;
  logic [1:0]  cfg_ss_dly;
  logic        miso, sck, mosi, ss_n, fifo_err;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  spi_ctl_port #(.SCK_HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_master(cfg_master), .cfg_three_wire(cfg_three_wire), .cfg_cpol(cfg_cpol),
    .cfg_ss_dly(cfg_ss_dly), .miso(miso), .sck(sck), .mosi(mosi), .ss_n(ss_n),
    .fifo_err(fifo_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Serial-side models
  logic [15:0] miso_sh;
  assign miso = miso_sh[15];
  always @(negedge sck) miso_sh = {miso_sh[14:0], 1'b0};

  logic        mon_en;
  int          pulses, ss_low;
  logic [15:0] cap;
  always @(posedge sck) if (mon_en) begin
    pulses = pulses + 1;
    cap = {cap[14:0], mosi};
  end
  always @(negedge clk) if (mon_en && !ss_n) ss_low = ss_low + 1;

  task automatic mon_reset();
    pulses = 0; ss_low = 0; cap = '0; mon_en = 1'b1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {write value, three-wire input, expected readback} -- R2, R3
  localparam logic [32:0] VEC [10] = '{
    {16'h0000, 1'b0, 16'h0280},
    {16'h2000, 1'b0, 16'h2280},
    {16'h1000, 1'b0, 16'h1280},
    {16'h1000, 1'b1, 16'h0280},
    {16'h0800, 1'b0, 16'h0A80},
    {16'h003F, 1'b0, 16'h02BF},
    {16'h03C0, 1'b0, 16'h0280},
    {16'h3A2D, 1'b1, 16'h2AAD},
    {16'h3A2D, 1'b0, 16'h3AAD},
    {16'h0000, 1'b0, 16'h0280}
  };

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    cfg_master = 1; cfg_three_wire = 0; cfg_cpol = 0; cfg_ss_dly = 2'd1;
    miso_sh = '0; mon_en = 0; pulses = 0; ss_low = 0; cap = '0;
    rst_n = 0;
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(2);

    // R1 reset state
    bus_read(0, rd); chk("R1", rd, 16'h0280);
    chk("R1", {15'd0, ss_n}, 16'd1);
    chk("R1", {14'd0, sck, mosi}, 16'd0);
    chk("R1", {15'd0, fifo_err}, 16'd0);

    // Table walk: R2, R3
    for (int i = 0; i < 10; i++) begin
      cfg_three_wire = VEC[i][16];
      bus_write(0, VEC[i][32:17]);
      bus_read(0, rd);
      chk(VEC[i][16] ? "R3" : "R2", rd, VEC[i][15:0]);
      chk("R4", {15'd0, ss_n}, 16'd1);
    end
    cfg_three_wire = 0;

    // R8 full byte, R4 automatic select window
    bus_write(0, 16'h0000);
    mon_reset();
    bus_write(1, 16'h00A5);
    wait_cyc(8*2*HALF + 8);
    chk("R8", pulses[15:0], 16'd8);
    chk("R8", cap & 16'h00FF, 16'h00A5);
    chk("R4", ss_low[15:0], 16'd32);
    bus_read(0, rd); chk("R5", rd, 16'h0280);

    // R8 partial byte: 3 bits of 0xC8
    bus_write(0, 16'h0018);
    mon_reset();
    bus_write(1, 16'h00C8);
    wait_cyc(3*2*HALF + 8);
    chk("R8", pulses[15:0], 16'd3);
    chk("R8", cap & 16'h0007, 16'h0006);
    chk("R4", ss_low[15:0], 16'd12);

    // R10 full duplex, 5 bits
    bus_write(0, 16'h1028);
    miso_sh = 16'hB000;
    mon_reset();
    bus_write(1, 16'h0000);
    wait_cyc(5*2*HALF + 8);
    chk("R10", pulses[15:0], 16'd5);
    bus_read(0, rd); chk("R10", rd, 16'h13A8);
    bus_read(1, rd); chk("R10", rd, 16'h0016);

    // R9 read phase, full byte
    miso_sh = 16'hC300;
    bus_write(0, 16'h0400);
    wait_cyc(8*2*HALF + 8);
    bus_read(0, rd); chk("R9", rd, 16'h0380);
    bus_read(1, rd); chk("R9", rd, 16'h00C3);

    // R9 partial read, 3 bits right-justified
    miso_sh = 16'hA000;
    bus_write(0, 16'h0403);
    wait_cyc(3*2*HALF + 8);
    bus_read(1, rd); chk("R9", rd, 16'h0005);

    // Write and read phase competing: R9 sticky, R8 order
    bus_write(0, 16'h0000);
    miso_sh = 16'h005A;
    mon_reset();
    bus_write(1, 16'h0081);
    bus_write(0, 16'h0400);
    bus_read(0, rd); chk("R9", rd, 16'h0680);
    wait_cyc(16*2*HALF + 10);
    chk("R9", pulses[15:0], 16'd16);
    chk("R8", cap, 16'h8100);
    bus_read(1, rd); chk("R9", rd, 16'h005A);
    bus_read(0, rd); chk("R9", rd, 16'h0280);

    // Slave mode: R12, R5, R6, R7
    cfg_master = 0;
    mon_reset();
    bus_write(0, 16'h0000);
    for (int i = 0; i < 8; i++) bus_write(1, 16'h0010 + 16'(i));
    bus_read(0, rd); chk("R5", rd, 16'h0000);
    chk("R6", {15'd0, fifo_err}, 16'd0);
    bus_write(1, 16'h0099);
    chk("R6", {15'd0, fifo_err}, 16'd1);
    bus_write(0, 16'h0400);
    wait_cyc(50);
    bus_read(0, rd); chk("R12", rd, 16'h0400);
    chk("R12", pulses[15:0], 16'd0);
    chk("R12", {15'd0, ss_n}, 16'd1);
    bus_write(0, 16'h8000);
    wait_cyc(4);
    chk("R11", pulses[15:0], 16'd0);
    bus_write(0, 16'h4000);
    bus_read(0, rd); chk("R7", rd, 16'h0280);
    chk("R7", {15'd0, fifo_err}, 16'd0);
    bus_read(1, rd); chk("R6", rd, 16'h0000);
    wait_cyc(5);
    chk("R6", {15'd0, fifo_err}, 16'd1);
    bus_write(0, 16'h4000);
    chk("R7", {15'd0, fifo_err}, 16'd0);
    cfg_master = 1;

    // R5 receive full via eight 1-bit reads
    miso_sh = 16'hFFFF;
    for (int i = 0; i < 8; i++) begin
      bus_write(0, 16'h0401);
      wait_cyc(12);
    end
    bus_read(0, rd); chk("R5", rd, 16'h03C1);
    bus_read(1, rd); chk("R5", rd, 16'h0001);
    bus_read(0, rd); chk("R5", rd, 16'h0381);
    bus_write(0, 16'h4000);

    // R11 clock burst in master mode
    mon_reset();
    bus_write(0, 16'h8000);
    bus_read(0, rd); chk("R11", rd, 16'h8280);
    wait_cyc(8*2*HALF + 8);
    chk("R11", pulses[15:0], 16'd8);
    chk("R11", cap & 16'h00FF, 16'h0000);
    chk("R4", ss_low[15:0], 16'd0);
    bus_read(0, rd); chk("R11", rd, 16'h0280);

    // R4 manual select
    cfg_ss_dly = 2'd0;
    bus_write(0, 16'h0800);
    chk("R4", {15'd0, ss_n}, 16'd0);
    bus_write(0, 16'h0000);
    chk("R4", {15'd0, ss_n}, 16'd1);
    cfg_ss_dly = 2'd2;
    bus_write(0, 16'h0800);
    chk("R4", {15'd0, ss_n}, 16'd1);
    bus_write(0, 16'h0000);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule